// File: doc/BRIEF.md
# Edge Event Timestamp Capture Unit

This block watches a single input pin, usually the demodulated output of an infrared receiver, and logs every transition as a 32-bit event word. Each word carries the level the pin moved to and the value of a free-running time counter that advances once every 75 ns. The counter tick comes from a fractional accumulator, so the clock period does not need to divide 75 ns. Event words go into a 16-deep queue. Software pops the queue through a small register read port and rebuilds the received character from the (time, direction) pairs.

The end of a character is found by silence, not by counting bits. After an edge, a quiet-period timer starts. When it expires, an idle status bit is set. A queue-fill status bit lets software drain long bursts before they run out of room. An overflow bit records that an edge was lost. Software clears each status bit by writing one to it. The interrupt line is the OR of the status bits that are enabled.

Register map (word address on `reg_addr`):
- 0, EVENT: reading it pops the oldest event.
- 1, FLAGS: [0] quiet, [1] fill, [2] lost, [12:8] occupancy. Writing one to bit 0, 1 or 2 clears that bit.
- 2, CONFIG: [2:0] interrupt enables in the same order as the FLAGS bits, [20:16] fill level.
- 3, QUIET: [23:0] quiet period in ticks.

The quiet-period timer is a two-state machine:
- DORMANT goes to COUNTING on any edge (transition `arm`).
- COUNTING restarts its count on an edge (transition `restart`).
- COUNTING returns to DORMANT when the count reaches the programmed period (transition `expire`). This sets the quiet flag.

Top module: `edge_stamp_top`

## Requirements
- R1: After reset the queue is empty, FLAGS reads zero and `irq` is low.
- R2: An event word has bit 31 = 1 for a rising edge and 0 for a falling edge, bits 30:24 zero, and the timestamp in bits 23:0.
- R3: Let N be the number of rising clock edges since reset release, up to and including the edge at which the first synchroniser flop samples the new pin level. The timestamp equals floor(N·CLK_PS/TICK_PS) modulo 2^24, which is floor(N·8000/75000) with default parameters.
- R4: Events are returned in arrival order. Each EVENT read pops one event. FLAGS[12:8] shows the occupancy.
- R5: Reading EVENT while the queue is empty returns zero and leaves the occupancy unchanged.
- R6: The quiet flag sets once the programmed number of ticks has passed after the last edge, and not before (period 20 ≈ 188 clock cycles at 125 MHz).
- R7: After the quiet flag has been set, it does not set again until a new edge has arrived.
- R8: The fill flag sets when a stored event leaves the occupancy at or above the CONFIG fill level. A fill level of 0 disables it.
- R9: An edge that arrives while the queue is full is discarded and sets the lost flag. Stored events are unchanged.
- R10: Writing one to a FLAGS bit clears it. Writing zero leaves it unchanged.
- R11: `irq` is high exactly when a set flag has its CONFIG enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Asynchronous pin being monitored |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on EVENT) |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the pin holds each level for at least three clock cycles, so that every change reaches the edge detector as a separate event. They also assume the register port carries only one access per cycle. The bench spaces its random edges between 3 and 100 cycles. The upper limit keeps every gap inside the quiet period, so a burst is never split. Reads happen only while the pin is steady, at least four cycles after a change. This keeps the bench's queue model in step with the cycle in which each edge is written. Read and write strobes are never raised together.

// File: rtl/edge_stamp_pkg.sv
package edge_stamp_pkg;
    localparam int STAMP_W   = 24;
    localparam int WORD_W    = 32;
    localparam int DIR_BIT   = 31;

    typedef enum logic [1:0] {
        REG_EVENT  = 2'd0,
        REG_FLAGS  = 2'd1,
        REG_CONFIG = 2'd2,
        REG_QUIET  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        QT_DORMANT  = 1'b0,
        QT_COUNTING = 1'b1
    } quiet_state_e;

    typedef struct packed {
        logic quiet;
        logic fill;
        logic lost;
    } flag_set_t;

    function automatic logic [WORD_W-1:0] pack_event(input logic dir,
                                                     input logic [STAMP_W-1:0] stamp);
        logic [WORD_W-1:0] w;
        w          = '0;
        w[DIR_BIT] = dir;
        w[STAMP_W-1:0] = stamp;
        return w;
    endfunction
endpackage

// File: rtl/edge_sync_detect.sv
module edge_sync_detect #(
    parameter int  STAGES     = 2,
    parameter logic IDLE_LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic edge_seen,
    output logic new_level
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= IDLE_LEVEL;
        else        chain[0] <= pin_in;
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= IDLE_LEVEL;
            else        chain[i] <= chain[i-1];
        end
    end

    assign new_level = chain[STAGES-1];
    assign edge_seen = chain[STAGES-1] ^ chain[STAGES];
endmodule

// File: rtl/stamp_clock.sv
module stamp_clock #(
    parameter int CLK_PS  = 8000,
    parameter int TICK_PS = 75000,
    parameter int STAMP_W = 24,
    parameter int DELAY   = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic               tick,
    output logic [STAMP_W-1:0] stamp_aligned
);
    localparam int ACC_W = $clog2(TICK_PS + CLK_PS + 1);

    logic [ACC_W-1:0]   acc;
    logic [ACC_W-1:0]   acc_sum;
    logic [STAMP_W-1:0] stamp_now;
    logic [STAMP_W-1:0] hist [DELAY+1];

    assign acc_sum = acc + ACC_W'(CLK_PS);
    assign tick    = (acc_sum >= ACC_W'(TICK_PS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc       <= '0;
            stamp_now <= '0;
        end else if (tick) begin
            acc       <= acc_sum - ACC_W'(TICK_PS);
            stamp_now <= stamp_now + 1'b1;
        end else begin
            acc       <= acc_sum;
        end
    end

    assign hist[0] = stamp_now;
    for (genvar d = 1; d <= DELAY; d++) begin : g_delay
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hist[d] <= '0;
            else        hist[d] <= hist[d-1];
        end
    end

    assign stamp_aligned = hist[DELAY];
endmodule

// File: rtl/event_queue.sv
module event_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] fill,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;

    assign full  = (fill == CW'(DEPTH));
    assign empty = (fill == '0);
    assign dout  = mem[rptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            unique case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/quiet_timer.sv
module quiet_timer
    import edge_stamp_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_seen,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic             expire,
    output quiet_state_e     state
);
    quiet_state_e     state_nx;
    logic [CNT_W-1:0] count, count_nx;
    logic [CNT_W-1:0] limit;

    assign limit = (period == '0) ? CNT_W'(1) : period;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= QT_DORMANT;
            count <= '0;
        end else begin
            state <= state_nx;
            count <= count_nx;
        end
    end

    always_comb begin
        state_nx = state;
        count_nx = count;
        expire   = 1'b0;
        unique case (state)
            QT_DORMANT: begin
                if (edge_seen) begin
                    state_nx = QT_COUNTING;
                    count_nx = '0;
                end
            end
            QT_COUNTING: begin
                if (edge_seen) begin
                    count_nx = '0;
                end else if (tick) begin
                    if (count + 1'b1 >= limit) begin
                        state_nx = QT_DORMANT;
                        count_nx = '0;
                        expire   = 1'b1;
                    end else begin
                        count_nx = count + 1'b1;
                    end
                end
            end
            default: state_nx = QT_DORMANT;
        endcase
    end
endmodule

// File: rtl/edge_stamp_top.sv
module edge_stamp_top
    import edge_stamp_pkg::*;
#(
    parameter int   CLK_PS        = 8000,
    parameter int   TICK_PS       = 75000,
    parameter int   DEPTH         = 16,
    parameter int   SYNC_STAGES   = 2,
    parameter logic PIN_IDLE      = 1'b0,
    parameter int   QUIET_DEFAULT = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_in,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq
);
    localparam int CW = $clog2(DEPTH + 1);

    logic               edge_seen, new_level, tick, expire;
    logic [STAMP_W-1:0] stamp;
    logic [WORD_W-1:0]  q_dout;
    logic [CW-1:0]      fill, fill_after;
    logic               full, empty, push, pop;
    quiet_state_e       qstate;

    flag_set_t          flags, flag_set, flag_en;
    logic [CW-1:0]      fill_level;
    logic [STAMP_W-1:0] quiet_period;

    edge_sync_detect #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(PIN_IDLE)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .edge_seen(edge_seen), .new_level(new_level)
    );

    stamp_clock #(.CLK_PS(CLK_PS), .TICK_PS(TICK_PS), .STAMP_W(STAMP_W),
                  .DELAY(SYNC_STAGES - 1)) u_clock (
        .clk(clk), .rst_n(rst_n), .tick(tick), .stamp_aligned(stamp)
    );

    assign pop  = reg_rd && (reg_addr == REG_EVENT) && !empty;
    assign push = edge_seen && (!full || pop);

    event_queue #(.DEPTH(DEPTH), .W(WORD_W)) u_queue (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .din(pack_event(new_level, stamp)), .dout(q_dout),
        .fill(fill), .full(full), .empty(empty)
    );

    quiet_timer #(.CNT_W(STAMP_W)) u_quiet (
        .clk(clk), .rst_n(rst_n), .edge_seen(edge_seen), .tick(tick),
        .period(quiet_period), .expire(expire), .state(qstate)
    );

    assign fill_after     = fill + CW'(push) - CW'(pop);
    assign flag_set.quiet = expire;
    assign flag_set.fill  = push && (fill_level != '0) && (fill_after >= fill_level);
    assign flag_set.lost  = edge_seen && !push;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags        <= '0;
            flag_en      <= '0;
            fill_level   <= '0;
            quiet_period <= STAMP_W'(QUIET_DEFAULT);
        end else begin
            if (reg_wr && reg_addr == REG_FLAGS)
                flags <= (flags & ~flag_set_t'({reg_wdata[0], reg_wdata[1], reg_wdata[2]}))
                         | flag_set;
            else
                flags <= flags | flag_set;
            if (reg_wr && reg_addr == REG_CONFIG) begin
                flag_en    <= flag_set_t'({reg_wdata[0], reg_wdata[1], reg_wdata[2]});
                fill_level <= reg_wdata[16 +: CW];
            end
            if (reg_wr && reg_addr == REG_QUIET)
                quiet_period <= reg_wdata[STAMP_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel_e'(reg_addr))
            REG_EVENT:  reg_rdata = empty ? '0 : q_dout;
            REG_FLAGS: begin
                reg_rdata[0]         = flags.quiet;
                reg_rdata[1]         = flags.fill;
                reg_rdata[2]         = flags.lost;
                reg_rdata[8 +: CW]   = fill;
            end
            REG_CONFIG: begin
                reg_rdata[0]         = flag_en.quiet;
                reg_rdata[1]         = flag_en.fill;
                reg_rdata[2]         = flag_en.lost;
                reg_rdata[16 +: CW]  = fill_level;
            end
            REG_QUIET:  reg_rdata[STAMP_W-1:0] = quiet_period;
            default:    reg_rdata = '0;
        endcase
    end

    assign irq = |(flags & flag_en);
endmodule

// File: rtl/edge_stamp_checker.sv
module edge_stamp_checker
    import edge_stamp_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_rd,
    input logic [1:0]    reg_addr,
    input logic [31:0]   reg_rdata,
    input logic [CW-1:0] fill,
    input logic          push,
    input logic          pop,
    input logic          edge_seen,
    input logic          lost_flag,
    input logic          quiet_flag,
    input quiet_state_e  qstate
);
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH)); // R9

    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0 && fill == '0) |-> (reg_rdata == '0)); // R5

    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0 && fill == '0 && !push) |=> $stable(fill)); // R5

    AST_LOST_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost_flag) |-> ($past(fill) == CW'(DEPTH))); // R9

    AST_QUIET_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(quiet_flag) |-> ($past(qstate) == QT_COUNTING)); // R7

    AST_EDGE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> (qstate == QT_COUNTING)); // R6

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> $stable(fill)); // R4
endmodule

bind edge_stamp_top edge_stamp_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_rdata(reg_rdata), .fill(fill), .push(push), .pop(pop),
    .edge_seen(edge_seen), .lost_flag(flags.lost), .quiet_flag(flags.quiet),
    .qstate(qstate)
);

// File: tb/sim_edge_stamp_top.sv
module sim_edge_stamp_top;
    localparam int CLK_PS  = 8000;
    localparam int TICK_PS = 75000;
    localparam int DEPTH   = 16;
    localparam int QUIET   = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_in = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0, fails = 0;
    longint cyc = 0;
    logic [31:0] model_q [$];
    logic exp_quiet = 0, exp_fill = 0, exp_lost = 0;
    int   fill_level = 0;
    bit   done = 0;

    always #4ns clk = ~clk;

    always @(posedge clk or negedge rst_n)
        if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

    edge_stamp_top u0 (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stamp_word(input bit dir, input longint n);
        longint t = (n * CLK_PS) / TICK_PS;
        return {dir, 7'd0, t[23:0]};
    endfunction

    function automatic logic [31:0] flags_word();
        return {19'd0, 5'(model_q.size()), 5'd0, exp_lost, exp_fill, exp_quiet};
    endfunction

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic toggle();
        @(negedge clk);
        pin_in = ~pin_in;
        if (model_q.size() < DEPTH) begin
            model_q.push_back(stamp_word(pin_in, cyc + 1));
            if (fill_level != 0 && model_q.size() >= fill_level) exp_fill = 1;
        end else begin
            exp_lost = 1;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pop_check(input string req);
        logic [31:0] v, e;
        rd(2'd0, v);
        e = (model_q.size() == 0) ? 32'd0 : model_q.pop_front();
        check(v === e, req, v, e);
    endtask

    task automatic drain(input string req);
        while (model_q.size() > 0) pop_check(req);
    endtask

    task automatic flags_check(input string req);
        logic [31:0] v;
        rd(2'd1, v);
        check(v === flags_word(), req, v, flags_word());
    endtask

    task automatic clear_all();
        wr(2'd1, 32'h7);
        exp_quiet = 0; exp_fill = 0; exp_lost = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        process::self().srandom(32'h5eed_1234);
        void'($urandom(32'hC0FFEE));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, v); check(v === 32'd0, "R1 flags", v, 32'd0);
        check(irq === 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
        pop_check("R5 empty read after reset");
        rd(2'd1, v); check(v === 32'd0, "R5 occupancy unchanged", v, 32'd0);

        wr(2'd3, QUIET);
        wr(2'd2, 32'h0000_0007);

        // R2 R3 R6 single rising edge, quiet timing
        toggle();
        idle(170);
        rd(2'd1, v); check(v[0] === 1'b0, "R6 quiet not early", v, 32'd0);
        idle(40);
        exp_quiet = 1;
        flags_check("R6 quiet set after period");
        check(irq === 1'b1, "R11 irq with enable", {31'd0, irq}, 32'd1);
        pop_check("R2 R3 rising entry");
        pop_check("R5 empty read returns zero");
        flags_check("R5 occupancy stays zero");

        // R10 write zero no effect, write one clears
        wr(2'd1, 32'h0);
        flags_check("R10 write zero keeps");
        wr(2'd1, 32'h1); exp_quiet = 0;
        flags_check("R10 write one clears");
        idle(400);
        flags_check("R7 no rearm without edge");
        check(irq === 1'b0, "R11 irq low when clear", {31'd0, irq}, 32'd0);

        // R4 random bursts with mid-burst reads
        for (int b = 0; b < 10; b++) begin
            int n = 1 + ($urandom % 12);
            for (int e = 0; e < n; e++) begin
                int gap = 3 + ($urandom % 98);
                toggle();
                if (gap >= 8 && ($urandom % 3) == 0) begin
                    idle(4);
                    pop_check("R4 mid-burst pop order");
                    idle(gap - 6);
                end else begin
                    idle(gap);
                end
            end
            idle(260);
            exp_quiet = 1;
            flags_check("R4 R6 burst flags");
            drain("R3 R4 burst order and stamps");
            clear_all();
        end

        // R8 fill flag
        wr(2'd2, 32'h0005_0007); fill_level = 5;
        for (int e = 0; e < 4; e++) begin toggle(); idle(10); end
        rd(2'd1, v); check(v[1] === 1'b0, "R8 fill below level", v, 32'd0);
        toggle(); idle(10);
        rd(2'd1, v); check(v[1] === 1'b1, "R8 fill at level", v, 32'd2);
        idle(260); exp_quiet = 1;
        flags_check("R8 fill flags");
        drain("R8 drain");
        clear_all();
        wr(2'd2, 32'h0000_0007); fill_level = 0;
        for (int e = 0; e < 6; e++) begin toggle(); idle(10); end
        idle(260); exp_quiet = 1;
        flags_check("R8 level zero disables");
        drain("R8 drain 2");
        clear_all();

        // R9 overflow
        for (int e = 0; e < DEPTH + 4; e++) begin toggle(); idle(5 + ($urandom % 20)); end
        idle(260); exp_quiet = 1;
        flags_check("R9 lost flag and full occupancy");
        drain("R9 stored entries intact");

        // R11 masking
        wr(2'd2, 32'h0000_0000);
        check(irq === 1'b0, "R11 masked irq", {31'd0, irq}, 32'd0);
        wr(2'd2, 32'h0000_0004);
        idle(1);
        check(irq === 1'b1, "R11 lost enable only", {31'd0, irq}, 32'd1);
        clear_all();
        idle(1);
        check(irq === 1'b0, "R10 R11 all cleared", {31'd0, irq}, 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule